// File: doc/BRIEF.md
# User Bit Block Manager

This block produces the user (U) bit that an AES3-style transmitter carries in each subframe. A mode input picks one of two behaviours. In zero mode every U bit is zero. In block mode the bits come from a full block of user data held in a double buffer.

The host fills a staging buffer one byte at a time. Each 16-bit word takes exactly two byte writes: the high byte first, then the low byte. The framer pulses a block-start strobe at each block boundary. On that strobe the whole staging buffer is copied in one cycle into a transmit buffer. A pointer then walks the transmit buffer one bit per subframe strobe.

Each word interleaves the two subframes. Bit 15 is A7, bit 14 is B7, bit 13 is A6, and so on down to bit 1 = A0 and bit 0 = B0. Walking each word from bit 15 down to bit 0 therefore sends the A bit and then the B bit of each pair, most significant first.

Top module: `ubit_block_mgr`

## Requirements
- R1: After reset both buffers hold zero, the pointer is at word 0 bit 15, the byte pairing expects a first byte, and `u_bit` is 0.
- R2: While `mode_blk` is 0, `u_bit` is 0 in every cycle, whatever the transmit buffer holds.
- R3: While `mode_blk` is 1, `u_bit` equals bit `ptr_bit` of transmit word `ptr_word`, taken from the current pointer.
- R4: Host bytes are paired. The first `hst_wr` of a pair latches `hst_addr` and the byte that becomes bits 15:8. The second `hst_wr` supplies bits 7:0 and ignores `hst_addr`. A pair whose latched address is 24 or more changes no word.
- R5: A staging word changes only when the second byte of its pair is written. A lone first byte leaves the staging buffer unchanged.
- R6: On `blk_start` all 24 staging words are copied into the transmit buffer at once. A pair that completes in the same cycle lands in the staging buffer but not in that copy.
- R7: `blk_start` sets the pointer to word 0 bit 15. It takes precedence over a `sf_strobe` in the same cycle.
- R8: Each `sf_strobe` without `blk_start` moves the pointer down one bit. After bit 0 it moves to bit 15 of the next word, so the output alternates A and B bits, MSB first.
- R9: A `sf_strobe` at word 23 bit 0 wraps the pointer to word 0 bit 15.
- R10: Host writes made while `mode_blk` is 0 are accepted. They appear at the output once the mode is 1 and a `blk_start` has copied them.
- R11: The transmit buffer changes only on `blk_start`. Host writes during a block do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_blk | input | 1 | 0 = send zeros, 1 = block mode |
| hst_wr | input | 1 | Host byte write strobe |
| hst_addr | input | 5 | Word address, used on the first byte of a pair |
| hst_data | input | 8 | Host byte |
| blk_start | input | 1 | Block boundary strobe from the framer |
| sf_strobe | input | 1 | Subframe strobe; the current bit is consumed and the pointer advances |
| u_bit | output | 1 | User bit for the current subframe |

## Verification
The bench targets several corner cases, and each one exposes a specific fault:
- A lone first byte followed by a block start. A design that commits half words would send the new high byte early.
- A pair that completes in the same cycle as a block start. A design that forwards the write into the copy would send it one block too soon.
- A block start coinciding with a subframe strobe. A design that lets the strobe win would start the block at bit 14.
- The wrap after 384 subframes, and writes to an out-of-range address. The first catches pointer overflow; the second catches aliasing onto a real word.
- Zero mode with a loaded buffer. This shows whether the gating leaks data.

// File: rtl/ubit_pkg.sv
`timescale 1ns/1ps
package ubit_pkg;
   typedef enum logic {
      UB_ZEROS = 1'b0,
      UB_BLOCK = 1'b1
   } ubit_mode_e;
endpackage

// File: rtl/ubit_host_buf.sv
`timescale 1ns/1ps
module ubit_host_buf #(
   parameter int WORDS  = 24,
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W,
   localparam int ADDR_W = $clog2(WORDS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         hst_wr,
   input  logic [ADDR_W-1:0]            hst_addr,
   input  logic [BYTE_W-1:0]            hst_data,
   output logic [WORDS-1:0][WORD_W-1:0] stage_mem
);
   logic              second_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] high_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         addr_q   <= '0;
         high_q   <= '0;
      end else if (hst_wr) begin
         second_q <= !second_q;
         if (!second_q) begin
            addr_q <= hst_addr;
            high_q <= hst_data;
         end
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              commit;
      assign commit = hst_wr && second_q && (addr_q == ADDR_W'(w));
      always_ff @(posedge clk) begin
         if (!rst_n)      word_q <= '0;
         else if (commit) word_q <= {high_q, hst_data};
      end
      assign stage_mem[w] = word_q;
   end

   // R5: a first byte alone never changes the staging buffer
   a_r5_first_byte_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && !second_q) |=> $stable(stage_mem));
   // R4: an out-of-range pair changes no word
   a_r4_range_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && second_q && addr_q >= ADDR_W'(WORDS)) |=> $stable(stage_mem));
endmodule

// File: rtl/ubit_tx_ser.sv
`timescale 1ns/1ps
module ubit_tx_ser #(
   parameter int WORDS  = 24,
   parameter int WORD_W = 16,
   localparam int WADR_W = $clog2(WORDS + 1),
   localparam int BIT_W  = $clog2(WORD_W),
   localparam logic [WADR_W-1:0] LAST_W = WADR_W'(WORDS - 1),
   localparam logic [BIT_W-1:0]  TOP_B  = BIT_W'(WORD_W - 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [WORDS-1:0][WORD_W-1:0] stage_mem,
   input  logic                         blk_start,
   input  logic                         sf_strobe,
   output logic                         raw_bit
);
   logic [WORDS-1:0][WORD_W-1:0] tx_mem;
   logic [WADR_W-1:0]            ptr_word;
   logic [BIT_W-1:0]             ptr_bit;

   always_ff @(posedge clk) begin
      if (!rst_n)         tx_mem <= '0;
      else if (blk_start) tx_mem <= stage_mem;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || blk_start) begin
         ptr_word <= '0;
         ptr_bit  <= TOP_B;
      end else if (sf_strobe) begin
         if (ptr_bit == '0) begin
            ptr_bit  <= TOP_B;
            ptr_word <= (ptr_word == LAST_W) ? '0 : ptr_word + 1'b1;
         end else begin
            ptr_bit <= ptr_bit - 1'b1;
         end
      end
   end

   assign raw_bit = tx_mem[ptr_word][ptr_bit];

   // R7: block start re-arms the pointer
   a_r7_ptr_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> (ptr_word == '0 && ptr_bit == TOP_B));
   // R8: step down within a word
   a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_strobe && !blk_start && ptr_bit != '0) |=>
         (ptr_bit == $past(ptr_bit) - 1'b1 && $stable(ptr_word)));
   // R9: wrap after the last bit of the last word
   a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_strobe && !blk_start && ptr_word == LAST_W && ptr_bit == '0) |=>
         (ptr_word == '0 && ptr_bit == TOP_B));
   // R11: transmit buffer only changes on block start
   a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_start |=> $stable(tx_mem));
   // R7: with no strobes the pointer holds
   a_r7_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_start && !sf_strobe) |=> ($stable(ptr_word) && $stable(ptr_bit)));
endmodule

// File: rtl/ubit_block_mgr.sv
`timescale 1ns/1ps
module ubit_block_mgr #(
   parameter int WORDS  = 24,
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W,
   localparam int ADDR_W = $clog2(WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_blk,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [BYTE_W-1:0] hst_data,
   input  logic              blk_start,
   input  logic              sf_strobe,
   output logic              u_bit
);
   import ubit_pkg::*;

   if (WORDS < 1) begin : g_bad_words
      $error("ubit_block_mgr: WORDS must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("ubit_block_mgr: BYTE_W must be at least 1");
   end

   logic [WORDS-1:0][WORD_W-1:0] stage_mem;
   logic                         raw_bit;
   ubit_mode_e                   mode;

   assign mode = mode_blk ? UB_BLOCK : UB_ZEROS;

   ubit_host_buf #(.WORDS(WORDS), .BYTE_W(BYTE_W)) u_host (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
      .hst_data(hst_data), .stage_mem(stage_mem)
   );

   ubit_tx_ser #(.WORDS(WORDS), .WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .stage_mem(stage_mem), .blk_start(blk_start),
      .sf_strobe(sf_strobe), .raw_bit(raw_bit)
   );

   assign u_bit = (mode == UB_BLOCK) ? raw_bit : 1'b0;

   // R2: zero mode never sends a one
   a_r2_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_blk |-> !u_bit);
endmodule

// File: tb/tb_ubit_block_mgr.sv
`timescale 1ns/1ps
module tb_ubit_block_mgr;
   localparam int WORDS = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_blk = 1'b0;
   logic       hst_wr = 1'b0;
   logic [4:0] hst_addr = '0;
   logic [7:0] hst_data = '0;
   logic       blk_start = 1'b0;
   logic       sf_strobe = 1'b0;
   logic       u_bit;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [15:0] hmem [WORDS];
   logic [15:0] tmem [WORDS];
   bit          m_second;
   logic [4:0]  m_addr;
   logic [7:0]  m_high;
   int          pw, pb;

   always #5 clk = ~clk;

   ubit_block_mgr dut (
      .clk(clk), .rst_n(rst_n), .mode_blk(mode_blk), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_data(hst_data), .blk_start(blk_start),
      .sf_strobe(sf_strobe), .u_bit(u_bit)
   );

   function automatic logic exp_bit();
      return mode_blk ? tmem[pw][pb] : 1'b0;
   endfunction

   task automatic check(input string tag);
      logic e;
      e = exp_bit();
      checks++;
      if (u_bit !== e) begin
         errors++;
         $display("FAIL %s: u_bit=%b expected %b (word %0d bit %0d)", tag, u_bit, e, pw, pb);
      end
   endtask

   task automatic model_edge(input bit wr, input logic [4:0] a, input logic [7:0] d,
                             input bit blk, input bit sf);
      if (blk) for (int i = 0; i < WORDS; i++) tmem[i] = hmem[i];
      if (wr) begin
         if (!m_second) begin
            m_addr = a; m_high = d; m_second = 1;
         end else begin
            if (m_addr < WORDS) hmem[m_addr] = {m_high, d};
            m_second = 0;
         end
      end
      if (blk) begin
         pw = 0; pb = 15;
      end else if (sf) begin
         if (pb == 0) begin
            pb = 15; pw = (pw == WORDS - 1) ? 0 : pw + 1;
         end else pb--;
      end
   endtask

   task automatic step(input bit wr, input logic [4:0] a, input logic [7:0] d,
                       input bit blk, input bit sf, input string tag);
      hst_wr = wr; hst_addr = a; hst_data = d; blk_start = blk; sf_strobe = sf;
      @(posedge clk);
      model_edge(wr, a, d, blk, sf);
      #1;
      hst_wr = 0; blk_start = 0; sf_strobe = 0;
      check(tag);
   endtask

   task automatic write_word(input logic [4:0] a, input logic [15:0] w, input string tag);
      step(1, a, w[15:8], 0, 0, tag);
      step(1, 5'd0, w[7:0], 0, 0, tag);
   endtask

   task automatic strobes(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, tag);
   endtask

   initial begin
      for (int i = 0; i < WORDS; i++) begin hmem[i] = '0; tmem[i] = '0; end
      m_second = 0; m_addr = '0; m_high = '0; pw = 0; pb = 15;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check("R1 reset output");
      mode_blk = 1;
      step(0, 0, 0, 1, 0, "R1 empty buffers");
      strobes(20, "R1 zero after reset");

      // R8 ordering: A7 B7 A6 B6 ... from bit 15 down
      write_word(5'd0, 16'hA5C3, "R4 pair write");
      write_word(5'd1, 16'h0F0F, "R4 pair write");
      step(0, 0, 0, 1, 0, "R6 transfer");
      strobes(40, "R8 bit order");

      // R5 lone first byte
      step(1, 5'd2, 8'hFF, 0, 0, "R5 first byte");
      step(0, 0, 0, 1, 0, "R5 transfer half");
      strobes(48, "R5 half word unsent");
      step(1, 5'd9, 8'h00, 0, 0, "R5 second byte");
      step(0, 0, 0, 1, 0, "R5 transfer full");
      strobes(48, "R5 full word sent");

      // R6 completion coincident with blk_start
      step(1, 5'd0, 8'h3C, 0, 0, "R6 first");
      step(1, 5'd0, 8'h81, 1, 0, "R6 same cycle");
      strobes(16, "R6 old word sent");
      step(0, 0, 0, 1, 0, "R6 next block");
      strobes(16, "R6 new word sent");

      // R11 writes mid-block do not alter output
      strobes(3, "R11 pre");
      write_word(5'd0, 16'hFFFF, "R11 mid write");
      strobes(13, "R11 unchanged");

      // R7 blk_start beats sf_strobe
      strobes(5, "R7 pre");
      step(0, 0, 0, 1, 1, "R7 precedence");
      strobes(2, "R7 after");

      // R4 out-of-range address
      write_word(5'd31, 16'hFFFF, "R4 out of range");
      step(0, 0, 0, 1, 0, "R4 transfer");
      for (int i = 0; i < WORDS * 16; i++) step(0, 0, 0, 0, 1, "R4 no alias");

      // R9 wrap: fill all words, go 384 strobes then more
      for (int i = 0; i < WORDS; i++) write_word(5'(i), 16'($urandom), "R9 fill");
      step(0, 0, 0, 1, 0, "R9 transfer");
      strobes(WORDS * 16 + 20, "R9 wrap");

      // R2 / R10 zero mode with loaded buffer and writes
      mode_blk = 0;
      strobes(30, "R2 zero mode");
      write_word(5'd3, 16'hFFFF, "R10 write in zero mode");
      step(0, 0, 0, 1, 0, "R10 transfer");
      strobes(50, "R2 still zero");
      mode_blk = 1;
      #1 check("R10 mode switch");
      strobes(60, "R10 data visible");

      // R3 random mix
      for (int i = 0; i < 4000; i++) begin
         bit wr, blk, sf;
         wr  = ($urandom % 4) == 0;
         blk = ($urandom % 97) == 0;
         sf  = ($urandom % 2) == 0;
         if (($urandom % 500) == 0) mode_blk = ~mode_blk;
         step(wr, 5'($urandom % 26), 8'($urandom), blk, sf, "R3 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, actual running expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule